// File: doc/BRIEF.md
# Guarded Write Unlock for Critical Registers

This block sits on a simple peripheral register bus and protects a small group of critical system registers, such as a standby-mode control register, from stray stores. Software unlocks the gate by storing any byte to a dedicated unlock address. The unlock is good for exactly one later bus write. If that write lands on a guarded register, the write goes through. Any other write uses up the unlock without effect. A guarded write that arrives while the gate is locked is discarded, and a sticky fault bit is set. Software can read the fault bit and clears it by writing 1.

The block decodes the bus address and keeps the unlock state. It issues a one-hot write strobe to the guarded register being updated, and it holds the guarded register contents. While the unlock store is on the bus, the block raises an interrupt-hold line. In the default build the line stays high for one more cycle. This lets the CPU's interrupt logic keep the unlock store and the store after it back to back.

Top module: `prot_wr_gate`

## Requirements
- R1: While reset is asserted, the gate is locked and the fault bit is 0. Each guarded register holds its reset value: index 0 = 0x00, 1 = 0xA5, 2 = 0x01, 3 = 0x00. `int_hold` and `wr_stb` are 0.
- R2: A byte write (`bus_size` = 2'b00) of any data to `CMD_ADDR` (default 0xFFFFF1FC) unlocks the gate. The next bus write, if it hits guarded register i, does two things. It raises `wr_stb[i]` in that cycle, and at the clock edge it loads `bus_wdata[7:0]` into that register.
- R3: A halfword (2'b01) or word (2'b10) write to `CMD_ADDR` does not unlock the gate, and it clears any unlock already present.
- R4: A guarded write while the gate is locked leaves the register unchanged and sets the fault bit (`prot_err`). The fault bit then stays set until it is cleared.
- R5: Every bus write uses up an unlock. This includes writes to unrelated addresses and to the fault address. A guarded write after such a write is discarded.
- R6: Reads need no unlock, return the guarded register value in `bus_rdata[7:0]` with the upper bits 0, and never change the unlock state.
- R7: `int_hold` is 1 in the cycle a byte write to `CMD_ADDR` is presented and in the cycle after it. At all other times it is 0.
- R8: A write to `ERR_ADDR` (default 0xFFFFF1F8) with bit 0 = 1 clears the fault bit, and a write with bit 0 = 0 leaves it unchanged. A read of `ERR_ADDR` returns the fault bit in bit 0.
- R9: `wr_stb` has at most one bit set, and only for a write that is accepted.
- R10: A read of `CMD_ADDR`, or of any unmapped address, returns 0. When no read is presented, `bus_rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | A bus access is presented this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW (32) | Byte address |
| bus_size | input | 2 | Access width: 00 byte, 01 halfword, 10 word |
| bus_wdata | input | DW (32) | Write data |
| bus_rdata | output | DW (32) | Read data, same cycle |
| prot_q | output | NPROT*REG_W (32) | Guarded register contents, index 0 in the low bits |
| wr_stb | output | NPROT (4) | One-hot update strobe for the guarded registers |
| prot_err | output | 1 | Sticky fault bit for a discarded guarded write |
| int_hold | output | 1 | Tells the CPU not to accept an interrupt |

## Verification
The assertions assume three things about the bus inputs:
- Each access lasts exactly one cycle.
- The inputs are stable around the rising edge.
- No access is presented during reset.

Under these assumptions, a store to the unlock address and the store after it are seen as two successive valid write cycles. The stimulus drives each access for one cycle, away from the edge, and holds `bus_valid` low throughout reset. It places idle cycles and reads between an unlock and the following write only where R5 and R6 call for them.

// File: rtl/pwg_pkg.sv
package pwg_pkg;
   typedef enum logic [1:0] {
      SZ_BYTE = 2'b00,
      SZ_HALF = 2'b01,
      SZ_WORD = 2'b10
   } acc_size_e;
endpackage

// File: rtl/pwg_decode.sv
module pwg_decode #(
   parameter int                  AW         = 32,
   parameter int                  NPROT      = 4,
   parameter logic [AW-1:0]       CMD_ADDR   = 32'hFFFFF1FC,
   parameter logic [AW-1:0]       ERR_ADDR   = 32'hFFFFF1F8,
   parameter logic [NPROT*AW-1:0] PROT_ADDRS = '0
) (
   input  logic             bus_valid,
   input  logic             bus_write,
   input  logic [AW-1:0]    bus_addr,
   input  logic [1:0]       bus_size,
   input  logic             wdata_b0,
   output logic             cmd_hit,
   output logic             any_wr,
   output logic             err_clr,
   output logic             rd_err,
   output logic [NPROT-1:0] wr_sel,
   output logic [NPROT-1:0] rd_sel
);
   import pwg_pkg::*;

   logic             wr_cyc;
   logic             rd_cyc;
   logic [NPROT-1:0] match;

   assign wr_cyc  = bus_valid &  bus_write;
   assign rd_cyc  = bus_valid & ~bus_write;
   assign any_wr  = wr_cyc;
   assign cmd_hit = wr_cyc & (bus_addr == CMD_ADDR) & (bus_size == SZ_BYTE);
   assign err_clr = wr_cyc & (bus_addr == ERR_ADDR) & wdata_b0;
   assign rd_err  = rd_cyc & (bus_addr == ERR_ADDR);

   for (genvar i = 0; i < NPROT; i++) begin : g_match
      assign match[i]  = (bus_addr == PROT_ADDRS[i*AW +: AW]);
      assign wr_sel[i] = wr_cyc & match[i];
      assign rd_sel[i] = rd_cyc & match[i];
   end
endmodule

// File: rtl/pwg_arm.sv
module pwg_arm #(
   parameter int NPROT       = 4,
   parameter bit HOLD_EXTEND = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_hit,
   input  logic             any_wr,
   input  logic             err_clr,
   input  logic [NPROT-1:0] wr_sel,
   output logic             armed_q,
   output logic             err_q,
   output logic             int_hold
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         armed_q <= 1'b0;
         err_q   <= 1'b0;
      end else begin
         if (any_wr) armed_q <= cmd_hit;
         if ((|wr_sel) && !armed_q) err_q <= 1'b1;
         else if (err_clr)          err_q <= 1'b0;
      end
   end

   if (HOLD_EXTEND) begin : g_hold_ext
      logic hold_q;
      always_ff @(posedge clk) begin
         if (!rst_n) hold_q <= 1'b0;
         else        hold_q <= cmd_hit;
      end
      assign int_hold = cmd_hit | hold_q;
   end else begin : g_hold_now
      assign int_hold = cmd_hit;
   end
endmodule

// File: rtl/pwg_regs.sv
module pwg_regs #(
   parameter int                     NPROT     = 4,
   parameter int                     REG_W     = 8,
   parameter int                     DW        = 32,
   parameter logic [NPROT*REG_W-1:0] PROT_RSTS = '0
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   armed,
   input  logic [NPROT-1:0]       wr_sel,
   input  logic [NPROT-1:0]       rd_sel,
   input  logic                   rd_err,
   input  logic                   err_bit,
   input  logic [REG_W-1:0]       wdata,
   output logic [NPROT-1:0]       wr_stb,
   output logic [NPROT*REG_W-1:0] regs_q,
   output logic [DW-1:0]          rdata
);
   for (genvar i = 0; i < NPROT; i++) begin : g_reg
      logic [REG_W-1:0] q;
      assign wr_stb[i] = wr_sel[i] & armed;
      always_ff @(posedge clk) begin
         if (!rst_n)         q <= PROT_RSTS[i*REG_W +: REG_W];
         else if (wr_stb[i]) q <= wdata;
      end
      assign regs_q[i*REG_W +: REG_W] = q;
   end

   always_comb begin
      rdata = '0;
      for (int i = 0; i < NPROT; i++) begin
         if (rd_sel[i]) rdata[REG_W-1:0] = regs_q[i*REG_W +: REG_W];
      end
      if (rd_err) rdata[0] = err_bit;
   end
endmodule

// File: rtl/prot_wr_gate.sv
module prot_wr_gate #(
   parameter int                     AW          = 32,
   parameter int                     DW          = 32,
   parameter int                     REG_W       = 8,
   parameter int                     NPROT       = 4,
   parameter bit                     HOLD_EXTEND = 1'b1,
   parameter logic [AW-1:0]          CMD_ADDR    = 32'hFFFFF1FC,
   parameter logic [AW-1:0]          ERR_ADDR    = 32'hFFFFF1F8,
   parameter logic [NPROT*AW-1:0]    PROT_ADDRS  = {32'hFFFFF8FC, 32'hFFFFF8F8,
                                                    32'hFFFFF8F4, 32'hFFFFF8F0},
   parameter logic [NPROT*REG_W-1:0] PROT_RSTS   = {8'h00, 8'h01, 8'hA5, 8'h00}
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   bus_valid,
   input  logic                   bus_write,
   input  logic [AW-1:0]          bus_addr,
   input  logic [1:0]             bus_size,
   input  logic [DW-1:0]          bus_wdata,
   output logic [DW-1:0]          bus_rdata,
   output logic [NPROT*REG_W-1:0] prot_q,
   output logic [NPROT-1:0]       wr_stb,
   output logic                   prot_err,
   output logic                   int_hold
);
   if (NPROT < 1 || NPROT > 8) begin : g_bad_nprot
      $error("prot_wr_gate: NPROT must be 1..8");
   end
   if (REG_W < 1 || REG_W >= DW) begin : g_bad_regw
      $error("prot_wr_gate: REG_W must be 1..DW-1");
   end
   if (CMD_ADDR == ERR_ADDR) begin : g_bad_err
      $error("prot_wr_gate: ERR_ADDR collides with CMD_ADDR");
   end
   for (genvar i = 0; i < NPROT; i++) begin : g_chk_addr
      if (PROT_ADDRS[i*AW +: AW] == CMD_ADDR || PROT_ADDRS[i*AW +: AW] == ERR_ADDR) begin : g_bad
         $error("prot_wr_gate: guarded address collides with a control address");
      end
   end

   logic             cmd_hit;
   logic             any_wr;
   logic             err_clr;
   logic             rd_err;
   logic [NPROT-1:0] wr_sel;
   logic [NPROT-1:0] rd_sel;
   logic             armed_q;
   logic             unused_hi;

   assign unused_hi = ^bus_wdata[DW-1:REG_W];

   pwg_decode #(
      .AW(AW), .NPROT(NPROT), .CMD_ADDR(CMD_ADDR),
      .ERR_ADDR(ERR_ADDR), .PROT_ADDRS(PROT_ADDRS)
   ) u_decode (
      .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
      .bus_size(bus_size), .wdata_b0(bus_wdata[0]),
      .cmd_hit(cmd_hit), .any_wr(any_wr), .err_clr(err_clr),
      .rd_err(rd_err), .wr_sel(wr_sel), .rd_sel(rd_sel)
   );

   pwg_arm #(.NPROT(NPROT), .HOLD_EXTEND(HOLD_EXTEND)) u_arm (
      .clk(clk), .rst_n(rst_n), .cmd_hit(cmd_hit), .any_wr(any_wr),
      .err_clr(err_clr), .wr_sel(wr_sel), .armed_q(armed_q),
      .err_q(prot_err), .int_hold(int_hold)
   );

   pwg_regs #(
      .NPROT(NPROT), .REG_W(REG_W), .DW(DW), .PROT_RSTS(PROT_RSTS)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .armed(armed_q), .wr_sel(wr_sel),
      .rd_sel(rd_sel), .rd_err(rd_err), .err_bit(prot_err),
      .wdata(bus_wdata[REG_W-1:0]), .wr_stb(wr_stb), .regs_q(prot_q),
      .rdata(bus_rdata)
   );
endmodule

// File: rtl/pwg_chk.sv
module pwg_chk #(
   parameter int            AW       = 32,
   parameter int            NPROT    = 4,
   parameter logic [AW-1:0] CMD_ADDR = 32'hFFFFF1FC
) (
   input logic             clk,
   input logic             rst_n,
   input logic             bus_valid,
   input logic             bus_write,
   input logic [AW-1:0]    bus_addr,
   input logic [1:0]       bus_size,
   input logic [NPROT-1:0] wr_stb,
   input logic             int_hold,
   input logic             prot_err,
   input logic             armed
);
   logic wr_cyc, cmd_byte, cmd_wide;
   assign wr_cyc   = bus_valid && bus_write;
   assign cmd_byte = wr_cyc && bus_addr == CMD_ADDR && bus_size == 2'b00;
   assign cmd_wide = wr_cyc && bus_addr == CMD_ADDR && bus_size != 2'b00;

   AST_STB_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(wr_stb)); // R9
   AST_STB_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
      (|wr_stb) |-> armed); // R2
   AST_CMD_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_byte |=> armed); // R2
   AST_CMD_HOLDS_INT: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_byte |-> int_hold); // R7
   AST_HOLD_NEXT_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_byte |=> int_hold); // R7
   AST_WIDE_NO_ARM: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_wide |=> !armed); // R3
   AST_WRITE_CONSUMES: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_cyc && bus_addr != CMD_ADDR) |=> !armed); // R5
   AST_READ_KEEPS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && !bus_write) |=> $stable(armed)); // R6
   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (prot_err && !wr_cyc) |=> prot_err); // R4
   AST_STB_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      (|wr_stb) |=> $stable(prot_err)); // R4
endmodule

bind prot_wr_gate pwg_chk #(.AW(AW), .NPROT(NPROT), .CMD_ADDR(CMD_ADDR)) u_pwg_chk (
   .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
   .bus_addr(bus_addr), .bus_size(bus_size), .wr_stb(wr_stb),
   .int_hold(int_hold), .prot_err(prot_err), .armed(armed_q)
);

// File: tb/prot_wr_gate_bench.sv
module prot_wr_gate_bench;
   localparam logic [31:0] A_CMD = 32'hFFFFF1FC;
   localparam logic [31:0] A_ERR = 32'hFFFFF1F8;
   localparam logic [31:0] A_OTH = 32'hFFFF0040;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_valid = 1'b0, bus_write = 1'b0;
   logic [31:0] bus_addr = '0, bus_wdata = '0;
   logic [1:0]  bus_size = 2'b00;
   logic [31:0] bus_rdata;
   logic [31:0] prot_q;
   logic [3:0]  wr_stb;
   logic        prot_err, int_hold;

   int n_cmp = 0, n_bad = 0;
   string cur_tag = "R1";

   logic [7:0] m_reg [4];
   bit         m_armed, m_err, m_hold_prev;

   always #5 clk = ~clk;

   prot_wr_gate u_prot_wr_gate (
      .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
      .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .prot_q(prot_q), .wr_stb(wr_stb),
      .prot_err(prot_err), .int_hold(int_hold)
   );

   function automatic int prot_idx(logic [31:0] a);
      for (int i = 0; i < 4; i++) if (a == 32'hFFFFF8F0 + 32'(4 * i)) return i;
      return -1;
   endfunction

   task automatic cmp(string tag, string what, logic [31:0] act, logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   task automatic model_reset();
      m_reg[0] = 8'h00; m_reg[1] = 8'hA5; m_reg[2] = 8'h01; m_reg[3] = 8'h00;
      m_armed = 0; m_err = 0; m_hold_prev = 0;
   endtask

   task automatic cyc(bit v, bit w, logic [31:0] a, logic [1:0] sz, logic [31:0] d);
      bit cmdb;
      int pi;
      logic [3:0]  e_stb;
      logic [31:0] e_rd;
      @(negedge clk);
      bus_valid = v; bus_write = w; bus_addr = a; bus_size = sz; bus_wdata = d;
      #1;
      cmdb  = v && w && a == A_CMD && sz == 2'b00;
      pi    = prot_idx(a);
      e_stb = (v && w && pi >= 0 && m_armed) ? 4'(1 << pi) : 4'b0;
      e_rd  = '0;
      if (v && !w && pi >= 0) e_rd = {24'b0, m_reg[pi]};
      if (v && !w && a == A_ERR) e_rd = {31'b0, m_err};
      cmp("R7", "int_hold", {31'b0, int_hold}, {31'b0, cmdb || m_hold_prev});
      cmp("R9", "wr_stb", {28'b0, wr_stb}, {28'b0, e_stb});
      cmp(cur_tag, "rdata", bus_rdata, e_rd);
      cmp(cur_tag, "prot_q", prot_q, {m_reg[3], m_reg[2], m_reg[1], m_reg[0]});
      cmp(cur_tag, "prot_err", {31'b0, prot_err}, {31'b0, m_err});
      @(posedge clk);
      m_hold_prev = cmdb;
      if (v && w) begin
         if (pi >= 0) begin
            if (m_armed) m_reg[pi] = d[7:0];
            else         m_err = 1;
         end
         if (a == A_ERR && d[0]) m_err = 0;
         m_armed = cmdb;
      end
   endtask

   task automatic idle();
      cyc(0, 0, '0, 2'b00, '0);
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog run did not finish");
      summary();
      $finish;
   end

   initial begin
      model_reset();
      repeat (3) @(posedge clk);
      // R1: outputs during reset
      @(negedge clk);
      cmp("R1", "int_hold in reset", {31'b0, int_hold}, 32'b0);
      cmp("R1", "wr_stb in reset", {28'b0, wr_stb}, 32'b0);
      cmp("R1", "prot_q in reset", prot_q, 32'h0001A500);
      cmp("R1", "prot_err in reset", {31'b0, prot_err}, 32'b0);
      rst_n = 1'b1;
      idle(); idle();
      // R6: reads of guarded registers with no unlock
      cur_tag = "R6";
      for (int i = 0; i < 4; i++) cyc(1, 0, 32'hFFFFF8F0 + 32'(4 * i), 2'b10, '0);
      // R2: unlock then guarded write, several data patterns
      cur_tag = "R2";
      for (int i = 0; i < 4; i++) begin
         cyc(1, 1, A_CMD, 2'b00, 32'(8'h5A ^ i));
         cyc(1, 1, 32'hFFFFF8F0 + 32'(4 * i), 2'b00, 32'h1234_5600 | 32'(8'h3C + 17 * i));
         idle();
      end
      // R4: guarded write while locked is discarded, fault is sticky
      cur_tag = "R4";
      cyc(1, 1, 32'hFFFFF8F4, 2'b00, 32'hFF);
      idle(); idle();
      cyc(1, 0, A_ERR, 2'b10, '0);
      // R8: write 0 keeps fault, write 1 clears it
      cur_tag = "R8";
      cyc(1, 1, A_ERR, 2'b10, 32'h0000_0000);
      cyc(1, 0, A_ERR, 2'b10, '0);
      cyc(1, 1, A_ERR, 2'b10, 32'h0000_0001);
      cyc(1, 0, A_ERR, 2'b10, '0);
      // R5: unrelated write consumes unlock
      cur_tag = "R5";
      cyc(1, 1, A_CMD, 2'b00, 32'h00);
      cyc(1, 1, A_OTH, 2'b10, 32'hDEAD_BEEF);
      cyc(1, 1, 32'hFFFFF8F0, 2'b00, 32'h77);
      cyc(1, 1, A_ERR, 2'b00, 32'h1);
      // R5: fault-address write also consumes unlock
      cyc(1, 1, A_CMD, 2'b00, 32'hC3);
      cyc(1, 1, A_ERR, 2'b00, 32'h0);
      cyc(1, 1, 32'hFFFFF8F8, 2'b00, 32'h66);
      cyc(1, 1, A_ERR, 2'b00, 32'h1);
      // R3: halfword and word unlock attempts do not unlock
      cur_tag = "R3";
      cyc(1, 1, A_CMD, 2'b01, 32'h0);
      cyc(1, 1, 32'hFFFFF8FC, 2'b00, 32'h99);
      cyc(1, 1, A_CMD, 2'b10, 32'h0);
      cyc(1, 1, 32'hFFFFF8FC, 2'b00, 32'h98);
      cyc(1, 1, A_CMD, 2'b00, 32'h0);
      cyc(1, 1, A_CMD, 2'b10, 32'h0);
      cyc(1, 1, 32'hFFFFF8FC, 2'b00, 32'h97);
      cyc(1, 1, A_ERR, 2'b00, 32'h1);
      // R6 / R10: reads and idle between unlock and write keep the unlock
      cur_tag = "R10";
      cyc(1, 1, A_CMD, 2'b00, 32'hAA);
      idle();
      cyc(1, 0, A_CMD, 2'b00, '0);
      cyc(1, 0, A_OTH, 2'b10, '0);
      cur_tag = "R6";
      cyc(1, 0, 32'hFFFFF8F8, 2'b10, '0);
      cyc(1, 1, 32'hFFFFF8F8, 2'b10, 32'h0000_00E1);
      // R7: back-to-back unlocks keep int_hold up, then guarded write
      cur_tag = "R7";
      cyc(1, 1, A_CMD, 2'b00, 32'h01);
      cyc(1, 1, A_CMD, 2'b00, 32'h02);
      cyc(1, 1, 32'hFFFFF8F0, 2'b00, 32'h4B);
      idle(); idle();
      // R9: second guarded write after an accepted one is discarded
      cur_tag = "R9";
      cyc(1, 1, A_CMD, 2'b00, 32'h10);
      cyc(1, 1, 32'hFFFFF8F4, 2'b00, 32'h21);
      cyc(1, 1, 32'hFFFFF8F4, 2'b00, 32'h22);
      idle();
      summary();
      $finish;
   end
endmodule